// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit words and a carry input in pure combinational logic, with no carry that travels bit by bit. Each bit position first classifies itself: when both operand bits are 1 it creates a carry. When exactly one is 1 it passes the incoming carry on. When both are 0 it absorbs any carry. Inside each 4-bit slice, every carry is formed directly as a sum of products of those per-bit terms and the slice's carry input. Each slice also reports whether it creates a carry on its own and whether it would pass a carry straight through.

A second lookahead stage takes the four slice-level terms and the adder's carry input. From them it forms the carry into every slice and the final carry out, using the same sum-of-products rule one level up. The whole-word create and pass-through terms are brought out as well, so that a wider adder could stack this block under a third lookahead level.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned values, for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned value `a_i + b_i + cin_i`.
- R3: `prop_o` is 1 exactly when every bit position has one operand bit set and the other clear, that is when `(a_i ^ b_i) == 16'hFFFF`. Otherwise it is 0, whatever the value of `cin_i`.
- R4: `gen_o` is 1 exactly when `a_i + b_i` with no carry input reaches or exceeds 2^16, independent of `cin_i`.
- R5: `cout_o` is 1 exactly when `gen_o` is 1, or when both `prop_o` and `cin_i` are 1.
- R6: A carry created in, or entering, a low 4-bit slice reaches every higher slice whose bits all pass it on. For example, `a_i=16'hFFFF`, `b_i=0` and `cin_i=1` give `sum_o=0` and `cout_o=1`. A carry made at bit 3 and passed on through bits 4 to 11 lands at bit 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| gen_o | output | 1 | Whole word creates a carry with no carry input |
| prop_o | output | 1 | Whole word passes a carry input straight through |

## Verification
The hardest case to reach is a carry that must cross several slice boundaries through long runs of pass-through bits. This is also the only case where `prop_o` goes high. Uniform random operands almost never produce it, because every one of the 16 bits would have to differ. The stimulus therefore adds a class of vectors where the second operand is the inverse of the first, with a few bits optionally flipped back. It also adds directed vectors that start a carry at a slice edge and let it run to the top.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned LA_MAXW = 16;

  function automatic logic bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic bit_prop(input logic a, input logic b);
    return a ^ b;
  endfunction

  // Carry into position idx: OR of each earlier generate term gated by
  // every propagate above it, plus the carry input gated by all of them.
  function automatic logic la_carry(input logic [LA_MAXW-1:0] g,
                                    input logic [LA_MAXW-1:0] p,
                                    input logic               c0,
                                    input int unsigned        idx);
    logic acc;
    logic term;
    acc = c0;
    for (int unsigned j = 0; j < idx; j++) acc = acc & p[j];
    for (int unsigned j = 0; j < idx; j++) begin
      term = g[j];
      for (int unsigned k = j + 1; k < idx; k++) term = term & p[k];
      acc = acc | term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c0_i,
  output logic [N:0]   c_o,
  output logic         gg_o,
  output logic         gp_o
);

  logic [LA_MAXW-1:0] g_x;
  logic [LA_MAXW-1:0] p_x;

  always_comb begin
    g_x = '0;
    p_x = '0;
    g_x[N-1:0] = g_i;
    p_x[N-1:0] = p_i;
  end

  always_comb begin
    for (int unsigned i = 0; i <= N; i++) c_o[i] = la_carry(g_x, p_x, c0_i, i);
  end

  assign gg_o = la_carry(g_x, p_x, 1'b0, N);
  assign gp_o = &p_i;

  // R3: with every position passing, each carry must mirror the carry input
  always_comb begin
    if (!$isunknown({p_i, c_o, c0_i}) && (&p_i)) begin
      for (int unsigned i = 0; i <= N; i++)
        a_r3_pass_through: assert (c_o[i] == c0_i);
    end
  end

  // R5: the last carry agrees with the group summary terms
  always_comb begin
    if (!$isunknown({g_i, p_i, c0_i}))
      a_r5_group_carry: assert (c_o[N] == (gg_o | (gp_o & c0_i)));
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         gg_o,
  output logic         gp_o
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:0]   bit_c;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_g[i] = bit_gen(a_i[i], b_i[i]);
    assign bit_p[i] = bit_prop(a_i[i], b_i[i]);
    assign sum_o[i] = bit_p[i] ^ bit_c[i];
  end

  cla_lookahead #(.N(W)) inner_la (
    .g_i  (bit_g),
    .p_i  (bit_p),
    .c0_i (cin_i),
    .c_o  (bit_c),
    .gg_o (gg_o),
    .gp_o (gp_o)
  );

  // R6: the slice's own carry out matches the true sum of its inputs
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}))
      a_r6_slice_carry: assert (bit_c[W] ==
        ((({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}) >> W) != 0));
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned GROUP_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             gen_o,
  output logic             prop_o
);

  localparam int unsigned NG = WIDTH / GROUP_W;

  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_p;
  logic [NG:0]   grp_c;

  for (genvar k = 0; k < NG; k++) begin : g_slice
    cla_group #(.W(GROUP_W)) slice_i (
      .a_i   (a_i[k*GROUP_W +: GROUP_W]),
      .b_i   (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i (grp_c[k]),
      .sum_o (sum_o[k*GROUP_W +: GROUP_W]),
      .gg_o  (grp_g[k]),
      .gp_o  (grp_p[k])
    );
  end

  cla_lookahead #(.N(NG)) outer_la (
    .g_i  (grp_g),
    .p_i  (grp_p),
    .c0_i (cin_i),
    .c_o  (grp_c),
    .gg_o (gen_o),
    .gp_o (prop_o)
  );

  assign cout_o = grp_c[NG];

  // R1 and R2: the lookahead result agrees with plain addition
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_sum: assert (sum_o == WIDTH'(a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i}));
      a_r2_cout: assert (cout_o ==
        (({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}) >> WIDTH != 0));
    end
  end

  // R4: a word that creates its own carry always carries out
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}) && gen_o)
      a_r4_gen_carries: assert (cout_o && !prop_o);
  end

endmodule

// File: tb/cla_adder16_tb_top.sv
module cla_adder16_tb_top;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout, gen, prop;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cla_adder16 dut_i (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .gen_o(gen), .prop_o(prop)
  );

  function automatic logic [16:0] ref_total(input logic [15:0] x, input logic [15:0] y,
                                            input logic c);
    logic [16:0] t;
    logic        cr;
    cr = c;
    for (int i = 0; i < 16; i++) begin
      t[i] = x[i] ^ y[i] ^ cr;
      cr   = (x[i] & y[i]) | (cr & (x[i] | y[i]));
    end
    t[16] = cr;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [16:0] tot;
    logic [16:0] tot0;
    logic        ep;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    tot  = ref_total(x, y, c);
    tot0 = ref_total(x, y, 1'b0);
    ep   = ((x ^ y) == 16'hFFFF);
    chk("R1 sum", sum, tot[15:0]);
    chk("R2 cout", {15'd0, cout}, {15'd0, tot[16]});
    chk("R3 prop", {15'd0, prop}, {15'd0, ep});
    chk("R4 gen", {15'd0, gen}, {15'd0, tot0[16]});
    chk("R5 cout vs gen/prop", {15'd0, cout}, {15'd0, tot0[16] | (ep & c)});
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    void'($urandom(32'h00C1A016));
    // all-zero starting vector
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R1 zero", sum, 16'h0000);
    // R6 directed boundary crossings
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R6 full run sum", sum, 16'h0000);
    chk("R6 full run cout", {15'd0, cout}, 16'd1);
    apply(16'h0FF8, 16'h0008, 1'b0);
    chk("R6 bit3 to bit12", sum, 16'h1000);
    apply(16'h00FF, 16'h0001, 1'b0);
    chk("R6 two slices", sum, 16'h0100);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h5555, 16'hAAAA, 1'b0);
    apply(16'h5555, 16'hAAAA, 1'b1);
    apply(16'h7FFF, 16'h0001, 1'b0);
    for (int n = 0; n < 1500; n++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    // near-complementary operands to reach long pass-through runs
    for (int n = 0; n < 500; n++) begin
      logic [15:0] x;
      logic [15:0] flip;
      x = 16'($urandom);
      flip = (n % 2 == 0) ? 16'h0000 : (16'h1 << ($urandom % 16));
      apply(x, ~x ^ flip, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule